// File: doc/BRIEF.md
# Input Capture Channel with Holding Queue

This block is one input-capture channel that sits next to a free-running 16-bit timer. When the edge detector in front of it reports a valid event, the channel stores the current timer count in its capture register. A second register, the holding register, can be switched on behind the capture register so that software has more time to read a timestamp before the next one overwrites it.

The holding register has two ways of being filled. In queue mode, every capture first pushes the previous capture value into the holding register. This gives a two-deep history of edge times. In latch mode, the capture register runs on its own, and the holding register takes a snapshot of it only when software pulses a latch strobe.

An interrupt flag reports activity. By default it rises on every capture. Under queue mode it can instead be made to rise only when the holding register receives a value. The capture register counts as empty from reset until its first capture. A capture into an empty register moves nothing into the holding register.

Top module: `capture_queue_channel`

## Requirements
- R1: When `capture_evt` is high at a rising clock edge, `cap_value` shows the `timer_count` present at that edge from the following cycle on. Without an event, `cap_value` holds its value.
- R2: While `buf_en` is 0, `hold_value` does not change, whatever `capture_evt` and `latch_stb` do.
- R3: Queue mode is `buf_en`=1 with `latch_sel`=0. In this mode, an event arriving when the capture register already holds a capture moves the old `cap_value` into `hold_value` at the same edge that loads the new count.
- R4: After reset the capture register is empty. In queue mode, the first event loads `cap_value` but leaves `hold_value` unchanged.
- R5: Latch mode is `buf_en`=1 with `latch_sel`=1. In this mode, `latch_stb` high at an edge copies `cap_value` into `hold_value`, and capture events never change `hold_value`.
- R6: In latch mode, when `latch_stb` and `capture_evt` are high at the same edge, `hold_value` receives the capture value from before that edge, and `cap_value` receives the new count.
- R7: With `flag_on_hold`=0, every capture event sets `cap_flag` at the next cycle.
- R8: With `flag_on_hold`=1 in queue mode, `cap_flag` is set only by an event that loads the holding register. The first capture after reset does not set it.
- R9: With `flag_on_hold`=1 outside queue mode, `cap_flag` is set by every capture event, the same as under R7.
- R10: `flag_clr` high at an edge clears `cap_flag`. A set at the same edge wins over the clear.
- R11: Asynchronous active-low reset clears `cap_value`, `hold_value` and `cap_flag` and marks the capture register empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_count | input | 16 | Free-running timer value |
| capture_evt | input | 1 | Edge-detected capture event, one cycle per edge |
| buf_en | input | 1 | Enables the holding register |
| latch_sel | input | 1 | 0 selects queue mode, 1 selects latch mode |
| flag_on_hold | input | 1 | In queue mode, sets the flag only on holding loads |
| latch_stb | input | 1 | Latch-mode strobe that copies capture into holding |
| flag_clr | input | 1 | Clears the interrupt flag |
| cap_value | output | 16 | Capture register |
| hold_value | output | 16 | Holding register |
| cap_flag | output | 1 | Channel interrupt flag |

## Verification
The hardest cases to reach are the empty-capture state and the collision of a latch strobe with a capture event. The empty state can only be reached through reset. The bench therefore resets the channel again inside the run, with queue mode and hold-only flagging already selected, and then sends a single event to show that the holding register and the flag stay unchanged. The collision is produced by raising the strobe and the event in the same cycle with a known older capture in place. Random phases then switch modes between events, comparing the outputs against a behavioural model every clock.

// File: rtl/capture_queue_channel.sv
module capture_queue_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] timer_count,
  input  logic          capture_evt,
  input  logic          buf_en,
  input  logic          latch_sel,
  input  logic          flag_on_hold,
  input  logic          latch_stb,
  input  logic          flag_clr,
  output logic [CW-1:0] cap_value,
  output logic [CW-1:0] hold_value,
  output logic          cap_flag
);

  logic cap_full;
  logic queue_mode, latch_mode, hold_load, flag_set;

  assign queue_mode = buf_en & ~latch_sel;
  assign latch_mode = buf_en & latch_sel;
  assign hold_load  = (queue_mode & capture_evt & cap_full) | (latch_mode & latch_stb);
  assign flag_set   = (flag_on_hold & queue_mode) ? (capture_evt & cap_full) : capture_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_value  <= '0;
      hold_value <= '0;
      cap_flag   <= 1'b0;
      cap_full   <= 1'b0;
    end else begin
      if (hold_load)
        hold_value <= cap_value;
      if (capture_evt) begin
        cap_value <= timer_count;
        cap_full  <= 1'b1;
      end
      if (flag_set)
        cap_flag <= 1'b1;
      else if (flag_clr)
        cap_flag <= 1'b0;
    end
  end

endmodule

module capture_queue_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] timer_count,
  input logic          capture_evt,
  input logic          buf_en,
  input logic          latch_sel,
  input logic          flag_on_hold,
  input logic          latch_stb,
  input logic          flag_clr,
  input logic [CW-1:0] cap_value,
  input logic [CW-1:0] hold_value,
  input logic          cap_flag,
  input logic          cap_full
);

  assert_cap_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> cap_value == $past(timer_count));

  assert_cap_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_evt |=> $stable(cap_value));

  assert_hold_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en |=> $stable(hold_value));

  assert_queue_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && !latch_sel && capture_evt && cap_full) |=> hold_value == $past(cap_value));

  assert_queue_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && !latch_sel && !cap_full) |=> $stable(hold_value));

  assert_latch_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && latch_sel && latch_stb) |=> hold_value == $past(cap_value));

  assert_latch_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && latch_sel && !latch_stb) |=> $stable(hold_value));

  assert_flag_every_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_evt && !(flag_on_hold && buf_en && !latch_sel)) |=> cap_flag);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_on_hold && buf_en && !latch_sel && !cap_flag && !(capture_evt && cap_full)) |=> !cap_flag);

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !capture_evt) |=> !cap_flag);

endmodule

bind capture_queue_channel capture_queue_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .timer_count(timer_count), .capture_evt(capture_evt),
  .buf_en(buf_en), .latch_sel(latch_sel), .flag_on_hold(flag_on_hold),
  .latch_stb(latch_stb), .flag_clr(flag_clr), .cap_value(cap_value),
  .hold_value(hold_value), .cap_flag(cap_flag), .cap_full(cap_full)
);

// File: tb/capture_queue_channel_test.sv
module capture_queue_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] timer_count = '0;
  logic        capture_evt = 1'b0, buf_en = 1'b0, latch_sel = 1'b0;
  logic        flag_on_hold = 1'b0, latch_stb = 1'b0, flag_clr = 1'b0;
  logic [15:0] cap_value, hold_value;
  logic        cap_flag;

  int checks = 0, fails = 0;
  bit finished = 0;

  int m_cap = 0, m_hold = 0, m_flag = 0, m_full = 0;

  always #5 clk = ~clk;
  always @(posedge clk) timer_count <= timer_count + 16'd1;

  capture_queue_channel uut (
    .clk(clk), .rst_n(rst_n), .timer_count(timer_count), .capture_evt(capture_evt),
    .buf_en(buf_en), .latch_sel(latch_sel), .flag_on_hold(flag_on_hold),
    .latch_stb(latch_stb), .flag_clr(flag_clr), .cap_value(cap_value),
    .hold_value(hold_value), .cap_flag(cap_flag)
  );

  task automatic compare(input string tag);
    checks++;
    if (cap_value !== 16'(m_cap) || hold_value !== 16'(m_hold) || cap_flag !== 1'(m_flag)) begin
      fails++;
      $display("FAIL %s: cap=%h hold=%h flag=%b expected cap=%h hold=%h flag=%0d",
               tag, cap_value, hold_value, cap_flag, 16'(m_cap), 16'(m_hold), m_flag);
    end
  endtask

  // drive at negedge, model the edge, compare at the next negedge
  task automatic step(input bit ev, input bit stb, input bit clr, input string tag);
    int t, q, l, set;
    capture_evt = ev; latch_stb = stb; flag_clr = clr;
    @(posedge clk);
    t = int'(timer_count);
    q = (buf_en && !latch_sel) ? 1 : 0;
    l = (buf_en && latch_sel) ? 1 : 0;
    set = (flag_on_hold && q) ? (ev && m_full) : ev;
    if ((q && ev && m_full) || (l && stb)) m_hold = m_cap;
    if (ev) begin m_cap = t; m_full = 1; end
    if (set) m_flag = 1; else if (clr) m_flag = 0;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    capture_evt = 0; latch_stb = 0; flag_clr = 0;
    rst_n = 0;
    @(negedge clk);
    m_cap = 0; m_hold = 0; m_flag = 0; m_full = 0;
    compare("R11 reset");
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();

    // R1, R2, R7: plain capture
    buf_en = 0; latch_sel = 0; flag_on_hold = 0;
    step(1, 0, 0, "R1 R7 capture");
    step(0, 1, 0, "R2 strobe ignored");
    step(0, 0, 1, "R10 clear");
    step(1, 1, 0, "R2 hold untouched");
    step(0, 0, 0, "R1 keep");

    // R4, R8: empty capture register in queue mode
    buf_en = 1; latch_sel = 0; flag_on_hold = 1;
    do_reset();
    step(1, 0, 0, "R4 R8 first capture no push");
    step(0, 0, 0, "R4 idle");
    step(1, 0, 0, "R3 R8 push sets flag");
    step(0, 0, 1, "R10 clear");
    step(1, 0, 1, "R10 set wins");
    step(0, 1, 0, "R3 strobe ignored in queue");

    // R7 in queue mode
    flag_on_hold = 0;
    do_reset();
    step(1, 0, 0, "R7 flag on first capture");
    step(1, 0, 0, "R3 push");

    // R5, R6, R9: latch mode
    latch_sel = 1; flag_on_hold = 1;
    step(0, 0, 1, "R10 clear");
    step(1, 0, 0, "R5 R9 event leaves hold");
    step(0, 1, 0, "R5 strobe copies");
    step(1, 1, 0, "R6 collision");
    step(0, 0, 0, "R6 idle");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ((i % 50) == 0) begin
        buf_en = 1'($urandom); latch_sel = 1'($urandom); flag_on_hold = 1'($urandom);
      end
      if ((i % 997) == 500) do_reset();
      step(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 3) == 0),
           1'($urandom_range(0, 3) == 0), "R1 R3 R5 R7 R8 R9 R10 random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule